// File: doc/BRIEF.md
# Doorbell-Driven Transfer Ring Consumer

This block is the device-side consumer of work rings kept in host memory. Each of its unidirectional channels owns one circular ring, described by a per-channel context that holds a base address, a ring length and a pair of indices. The host writes a channel's base and length through a setup port, which also zeroes both indices. To post work, the host fills ring slots in memory, advances its write index and writes that index through the channel's doorbell.

Whenever any channel holds unserviced slots, the engine picks a channel in round-robin order. It reads the slot at the channel's read index through a single-outstanding memory read port and hands the buffer address and length to a data-mover port. It then advances the read index and keeps going while the chain bit of the slot is set. When a slot without the chain bit ends the descriptor, the engine emits one completion record with the channel, the summed byte count and a status code.

Top module: `xre_engine`

## Requirements
- R1: After reset, `mem_req_valid`, `mv_valid`, `cpl_valid` and `db_err` are all low.
- R2: A slot is fetched from address base + 16 × read index. Slots are serviced in ring order, and the read index wraps from ring length − 1 back to 0.
- R3: Each fetched slot is passed to the data mover with `mv_addr` = slot bits [63:0] and `mv_len` = slot bits [79:64].
- R4: Slot bit 80 is the chain bit. A run of slots with the bit set, closed by a slot with it clear, produces exactly one completion whose byte count is the sum of their lengths.
- R5: Completion status is 0 when every slot of the descriptor had a nonzero length and 1 when any slot had length zero. The status starts afresh for each descriptor.
- R6: A ring whose read index equals its write index is empty and is never fetched from. A descriptor whose chain reaches the write index waits, with no fetch and no completion, until a doorbell adds slots.
- R7: Channels holding unserviced slots are granted one whole descriptor at a time, in rotating order starting after the last channel granted.
- R8: A doorbell whose channel is at or above the channel count, or whose write index is not below that channel's ring length, changes no context and sets `db_err`, which stays set until reset.
- R9: `mem_req_valid`, `mv_valid` and `cpl_valid` stay high with stable payload until their ready input is seen high, and at most one of them is high at a time.
- R10: A full ring (write index + 1 ≡ read index modulo the ring length) yields ring length − 1 slots, after which further doorbells continue from the wrapped read index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Context setup strobe |
| cfg_ch | input | DB_CH_W | Channel being set up |
| cfg_base | input | ADDR_W | Ring base byte address |
| cfg_rlen | input | PTR_W | Ring length in slots (at least 2) |
| db_wr | input | 1 | Doorbell write strobe |
| db_ch | input | DB_CH_W | Doorbell channel number |
| db_wp | input | PTR_W | New write index |
| db_err | output | 1 | Sticky bad-doorbell flag |
| mem_req_valid | output | 1 | Slot read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Slot byte address |
| mem_rsp_valid | input | 1 | Slot read data valid |
| mem_rsp_data | input | 128 | Slot contents |
| mv_valid | output | 1 | Buffer handed to data mover |
| mv_ready | input | 1 | Data mover accepts buffer |
| mv_addr | output | 64 | Buffer address |
| mv_len | output | LEN_W | Buffer length in bytes |
| cpl_valid | output | 1 | Completion record valid |
| cpl_ready | input | 1 | Completion consumer ready |
| cpl_ch | output | CH_W | Channel of completed descriptor |
| cpl_bytes | output | LEN_W+PTR_W | Total bytes of descriptor |
| cpl_status | output | 2 | 0 ok, 1 zero-length slot seen |

## Verification
On every cycle the assertions check that the three output handshakes hold their payload while stalled and never overlap. They also check that a fetch is only issued for a channel whose ring is not empty, and that a bad doorbell raises the error flag, which never drops again. Byte sums across chains, slot addresses around the wrap, rotating grant order, waiting on a half-posted chain, per-descriptor status and the fact that bad doorbells leave the rings untouched are shown only by the bench's scenarios, which compare against values computed from the slot contents the bench itself placed in memory.

// File: rtl/xre_pkg.sv
package xre_pkg;
  localparam int SLOT_W     = 128;
  localparam int SLOT_SHIFT = 4;
  localparam int LEN_LSB    = 64;
  localparam int CHAIN_BIT  = 80;

  localparam logic [1:0] STAT_OK   = 2'd0;
  localparam logic [1:0] STAT_ZLEN = 2'd1;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_RSP, S_MOVE, S_WAITDB, S_CPL
  } eng_st_t;

  // next ring index, wrapping at the ring length
  function automatic int unsigned ring_next(int unsigned idx, int unsigned rlen);
    return (idx + 1 >= rlen) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/xre_ctx.sv
module xre_ctx #(
  parameter int NUM_CH  = 4,
  parameter int CH_W    = 2,
  parameter int PTR_W   = 8,
  parameter int ADDR_W  = 64,
  parameter int DB_CH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [DB_CH_W-1:0] cfg_ch,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [PTR_W-1:0]   cfg_rlen,
  input  logic               db_wr,
  input  logic [DB_CH_W-1:0] db_ch,
  input  logic [PTR_W-1:0]   db_wp,
  input  logic               adv,
  input  logic [CH_W-1:0]    adv_ch,
  input  logic [CH_W-1:0]    sel_ch,
  output logic [ADDR_W-1:0]  sel_base,
  output logic [PTR_W-1:0]   sel_rp,
  output logic [NUM_CH-1:0]  pend,
  output logic               db_bad,
  output logic               err
);
  import xre_pkg::*;

  logic [ADDR_W-1:0] base_q [NUM_CH];
  logic [PTR_W-1:0]  rlen_q [NUM_CH];
  logic [PTR_W-1:0]  rp_q   [NUM_CH];
  logic [PTR_W-1:0]  wp_q   [NUM_CH];

  logic            db_in_rng;
  logic [CH_W-1:0] db_idx;

  assign db_in_rng = db_ch < DB_CH_W'(NUM_CH);
  assign db_idx    = db_ch[CH_W-1:0];
  assign db_bad    = db_wr && (!db_in_rng || db_wp >= rlen_q[db_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
        base_q[i] <= '0;
        rlen_q[i] <= '0;
        rp_q[i]   <= '0;
        wp_q[i]   <= '0;
      end
    end else begin
      if (db_bad) err <= 1'b1;
      for (int i = 0; i < NUM_CH; i++) begin
        if (cfg_wr && cfg_ch == DB_CH_W'(i)) begin
          base_q[i] <= cfg_base;
          rlen_q[i] <= cfg_rlen;
          rp_q[i]   <= '0;
          wp_q[i]   <= '0;
        end else begin
          if (db_wr && !db_bad && db_ch == DB_CH_W'(i)) wp_q[i] <= db_wp;
          if (adv && adv_ch == CH_W'(i))
            rp_q[i] <= PTR_W'(ring_next(int'(rp_q[i]), int'(rlen_q[i])));
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_pend
    assign pend[g] = rp_q[g] != wp_q[g];
  end

  assign sel_base = base_q[sel_ch];
  assign sel_rp   = rp_q[sel_ch];
endmodule

// File: rtl/xre_rr.sv
module xre_rr #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_q) + k) % N;
      if (!gnt_any && req[c]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= IW'(N - 1);
    else if (take) last_q <= gnt_idx;
  end
endmodule

// File: rtl/xre_engine.sv
module xre_engine #(
  parameter int NUM_CH  = 4,
  parameter int PTR_W   = 8,
  parameter int ADDR_W  = 64,
  parameter int LEN_W   = 16,
  parameter int DB_CH_W = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BYTE_W = LEN_W + PTR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [DB_CH_W-1:0] cfg_ch,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [PTR_W-1:0]   cfg_rlen,
  input  logic               db_wr,
  input  logic [DB_CH_W-1:0] db_ch,
  input  logic [PTR_W-1:0]   db_wp,
  output logic               db_err,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [127:0]       mem_rsp_data,
  output logic               mv_valid,
  input  logic               mv_ready,
  output logic [63:0]        mv_addr,
  output logic [LEN_W-1:0]   mv_len,
  output logic               cpl_valid,
  input  logic               cpl_ready,
  output logic [CH_W-1:0]    cpl_ch,
  output logic [BYTE_W-1:0]  cpl_bytes,
  output logic [1:0]         cpl_status
);
  import xre_pkg::*;

  function automatic logic [ADDR_W-1:0] slot_addr(logic [ADDR_W-1:0] base,
                                                  logic [PTR_W-1:0] idx);
    return base + (ADDR_W'(idx) << SLOT_SHIFT);
  endfunction

  eng_st_t           st_q;
  logic [CH_W-1:0]   ch_q;
  logic [63:0]       buf_q;
  logic [LEN_W-1:0]  len_q;
  logic              chain_q;
  logic [BYTE_W-1:0] bytes_q;
  logic [1:0]        stat_q;

  logic [ADDR_W-1:0] sel_base;
  logic [PTR_W-1:0]  sel_rp;
  logic [NUM_CH-1:0] pend;
  logic              db_bad;
  logic [CH_W-1:0]   gnt_idx;
  logic              gnt_any;

  // named internal events
  logic grant_take, fetch_fire, slot_fire, mv_fire, cpl_fire, act_pend;

  assign grant_take = (st_q == S_IDLE) && gnt_any;
  assign fetch_fire = mem_req_valid && mem_req_ready;
  assign slot_fire  = (st_q == S_RSP) && mem_rsp_valid;
  assign mv_fire    = mv_valid && mv_ready;
  assign cpl_fire   = cpl_valid && cpl_ready;
  assign act_pend   = pend[ch_q];

  xre_ctx #(.NUM_CH(NUM_CH), .CH_W(CH_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W),
            .DB_CH_W(DB_CH_W)) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_base(cfg_base), .cfg_rlen(cfg_rlen),
    .db_wr(db_wr), .db_ch(db_ch), .db_wp(db_wp),
    .adv(mv_fire), .adv_ch(ch_q), .sel_ch(ch_q),
    .sel_base(sel_base), .sel_rp(sel_rp), .pend(pend),
    .db_bad(db_bad), .err(db_err)
  );

  xre_rr #(.N(NUM_CH), .IW(CH_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(pend), .take(grant_take),
    .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      ch_q    <= '0;
      buf_q   <= '0;
      len_q   <= '0;
      chain_q <= 1'b0;
      bytes_q <= '0;
      stat_q  <= STAT_OK;
    end else begin
      case (st_q)
        S_IDLE: if (grant_take) begin
          ch_q    <= gnt_idx;
          bytes_q <= '0;
          stat_q  <= STAT_OK;
          st_q    <= S_REQ;
        end
        S_REQ: if (fetch_fire) st_q <= S_RSP;
        S_RSP: if (slot_fire) begin
          buf_q   <= mem_rsp_data[63:0];
          len_q   <= mem_rsp_data[LEN_LSB +: LEN_W];
          chain_q <= mem_rsp_data[CHAIN_BIT];
          bytes_q <= bytes_q + BYTE_W'(mem_rsp_data[LEN_LSB +: LEN_W]);
          if (mem_rsp_data[LEN_LSB +: LEN_W] == '0) stat_q <= STAT_ZLEN;
          st_q    <= S_MOVE;
        end
        S_MOVE: if (mv_fire) st_q <= chain_q ? S_WAITDB : S_CPL;
        S_WAITDB: if (act_pend) st_q <= S_REQ;
        S_CPL: if (cpl_fire) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_addr  = slot_addr(sel_base, sel_rp);
  assign mv_valid      = (st_q == S_MOVE);
  assign mv_addr       = buf_q;
  assign mv_len        = len_q;
  assign cpl_valid     = (st_q == S_CPL);
  assign cpl_ch        = ch_q;
  assign cpl_bytes     = bytes_q;
  assign cpl_status    = stat_q;
endmodule

// File: rtl/xre_chk.sv
module xre_chk #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 16,
  parameter int CH_W   = 2,
  parameter int BYTE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mv_valid,
  input logic              mv_ready,
  input logic [63:0]       mv_addr,
  input logic [LEN_W-1:0]  mv_len,
  input logic              cpl_valid,
  input logic              cpl_ready,
  input logic [CH_W-1:0]   cpl_ch,
  input logic [BYTE_W-1:0] cpl_bytes,
  input logic              db_err,
  input logic              db_bad,
  input logic              act_pend
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R9
  mv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && !mv_ready |=> mv_valid && $stable(mv_addr) && $stable(mv_len));
  // R9
  cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_ch) && $stable(cpl_bytes));
  // R9
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid, mv_valid, cpl_valid}));
  // R6
  fetch_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> act_pend);
  // R8
  bad_db_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_bad |=> db_err);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_err |=> db_err);
endmodule

bind xre_engine xre_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CH_W(CH_W),
                          .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr),
  .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_addr(mv_addr), .mv_len(mv_len),
  .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_ch(cpl_ch),
  .cpl_bytes(cpl_bytes),
  .db_err(db_err), .db_bad(db_bad), .act_pend(act_pend)
);

// File: tb/xre_engine_tb.sv
module xre_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_ch = '0;
  logic [63:0] cfg_base = '0;
  logic [7:0]  cfg_rlen = '0;
  logic        db_wr = 1'b0;
  logic [7:0]  db_ch = '0;
  logic [7:0]  db_wp = '0;
  logic        db_err;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;
  logic        mv_valid;
  logic        mv_ready = 1'b1;
  logic [63:0] mv_addr;
  logic [15:0] mv_len;
  logic        cpl_valid;
  logic        cpl_ready = 1'b1;
  logic [1:0]  cpl_ch;
  logic [23:0] cpl_bytes;
  logic [1:0]  cpl_status;

  int checks = 0;
  int errors = 0;

  logic [127:0] mem [256];
  logic [63:0]  fetch_log [256];
  logic [63:0]  mva_log [256];
  logic [15:0]  mvl_log [256];
  logic [1:0]   cch_log [256];
  logic [23:0]  cby_log [256];
  logic [1:0]   cst_log [256];
  int fetch_n = 0, mv_n = 0, cpl_n = 0;

  always #4 clk = ~clk;

  xre_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_base(cfg_base), .cfg_rlen(cfg_rlen),
    .db_wr(db_wr), .db_ch(db_ch), .db_wp(db_wp), .db_err(db_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_addr(mv_addr), .mv_len(mv_len),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_ch(cpl_ch),
    .cpl_bytes(cpl_bytes), .cpl_status(cpl_status)
  );

  // memory model and output monitors
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[11:4]];
      fetch_log[fetch_n[7:0]] <= mem_req_addr;
      fetch_n <= fetch_n + 1;
    end
    if (mv_valid && mv_ready) begin
      mva_log[mv_n[7:0]] <= mv_addr;
      mvl_log[mv_n[7:0]] <= mv_len;
      mv_n <= mv_n + 1;
    end
    if (cpl_valid && cpl_ready) begin
      cch_log[cpl_n[7:0]] <= cpl_ch;
      cby_log[cpl_n[7:0]] <= cpl_bytes;
      cst_log[cpl_n[7:0]] <= cpl_status;
      cpl_n <= cpl_n + 1;
    end
  end

  function automatic logic [127:0] slot(logic [63:0] p, logic [15:0] l, bit chain);
    return {47'b0, chain, l, p};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input int ch, input logic [63:0] base, input int rlen);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ch = 8'(ch); cfg_base = base; cfg_rlen = 8'(rlen);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic ring(input int ch, input int wp);
    @(negedge clk);
    db_wr = 1'b1; db_ch = 8'(ch); db_wp = 8'(wp);
    @(negedge clk);
    db_wr = 1'b0;
  endtask

  task automatic wait_cpl(input int target);
    for (int i = 0; i < 3000 && cpl_n < target; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!mem_req_valid && !mv_valid && !cpl_valid && !db_err, "R1 reset outputs",
        {mem_req_valid, mv_valid, cpl_valid, db_err}, 0);
  endtask

  task automatic t_single();
    int c0, f0, m0;
    c0 = cpl_n; f0 = fetch_n; m0 = mv_n;
    setup(0, 64'h0, 8);
    mem[0] = slot(64'hAAA0, 16'd100, 1'b0);
    ring(0, 1);
    wait_cpl(c0 + 1);
    chk(fetch_log[f0[7:0]] == 64'h0, "R2 slot address", fetch_log[f0[7:0]], 0);
    chk(mva_log[m0[7:0]] == 64'hAAA0, "R3 mover addr", mva_log[m0[7:0]], 64'hAAA0);
    chk(mvl_log[m0[7:0]] == 16'd100, "R3 mover len", mvl_log[m0[7:0]], 100);
    chk(cch_log[c0[7:0]] == 2'd0 && cby_log[c0[7:0]] == 24'd100,
        "R4 single completion", cby_log[c0[7:0]], 100);
  endtask

  task automatic t_chain();
    int c0, m0;
    c0 = cpl_n; m0 = mv_n;
    setup(1, 64'h100, 4);
    mem[16] = slot(64'h1000, 16'd10, 1'b1);
    mem[17] = slot(64'h2000, 16'd20, 1'b1);
    mem[18] = slot(64'h3000, 16'd30, 1'b0);
    ring(1, 3);
    wait_cpl(c0 + 1);
    repeat (30) @(negedge clk);
    chk(cpl_n == c0 + 1, "R4 one completion per chain", 64'(cpl_n - c0), 1);
    chk(cby_log[c0[7:0]] == 24'd60, "R4 chained byte sum", cby_log[c0[7:0]], 60);
    chk(cch_log[c0[7:0]] == 2'd1, "R4 completion channel", cch_log[c0[7:0]], 1);
    chk(mv_n == m0 + 3, "R3 one mover hand-off per slot", 64'(mv_n - m0), 3);
    chk(mva_log[(m0 + 2) % 256] == 64'h3000, "R3 last mover addr",
        mva_log[(m0 + 2) % 256], 64'h3000);
  endtask

  task automatic t_zero();
    int c0;
    c0 = cpl_n;
    setup(1, 64'h100, 4);
    mem[16] = slot(64'h4000, 16'd0, 1'b1);
    mem[17] = slot(64'h5000, 16'd5, 1'b0);
    mem[18] = slot(64'h6000, 16'd7, 1'b0);
    ring(1, 2);
    wait_cpl(c0 + 1);
    chk(cst_log[c0[7:0]] == 2'd1, "R5 zero-length status", cst_log[c0[7:0]], 1);
    chk(cby_log[c0[7:0]] == 24'd5, "R5 zero-length bytes", cby_log[c0[7:0]], 5);
    ring(1, 3);
    wait_cpl(c0 + 2);
    chk(cst_log[(c0 + 1) % 256] == 2'd0, "R5 status clears per descriptor",
        cst_log[(c0 + 1) % 256], 0);
  endtask

  task automatic t_wrap();
    int c0, f0;
    c0 = cpl_n; f0 = fetch_n;
    setup(2, 64'h200, 4);
    for (int i = 0; i < 4; i++) mem[32 + i] = slot(64'h7000 + 64'(i), 16'(i + 1), 1'b0);
    ring(2, 3);
    wait_cpl(c0 + 3);
    repeat (20) @(negedge clk);
    chk(cpl_n == c0 + 3, "R10 full ring yields length-1", 64'(cpl_n - c0), 3);
    chk(fetch_log[(f0 + 2) % 256] == 64'h220, "R2 third slot address",
        fetch_log[(f0 + 2) % 256], 64'h220);
    ring(2, 1);
    wait_cpl(c0 + 5);
    chk(fetch_log[(f0 + 3) % 256] == 64'h230, "R2 last slot before wrap",
        fetch_log[(f0 + 3) % 256], 64'h230);
    chk(fetch_log[(f0 + 4) % 256] == 64'h200, "R10 wrapped slot address",
        fetch_log[(f0 + 4) % 256], 64'h200);
    chk(cby_log[(c0 + 4) % 256] == 24'd1, "R2 wrapped slot bytes",
        cby_log[(c0 + 4) % 256], 1);
  endtask

  task automatic t_wait();
    int c0, f0;
    c0 = cpl_n; f0 = fetch_n;
    setup(3, 64'h300, 8);
    repeat (10) @(negedge clk);
    chk(fetch_n == f0, "R6 empty ring not fetched", 64'(fetch_n - f0), 0);
    mem[48] = slot(64'h8000, 16'd11, 1'b1);
    mem[49] = slot(64'h9000, 16'd22, 1'b0);
    ring(3, 1);
    repeat (40) @(negedge clk);
    chk(cpl_n == c0 && fetch_n == f0 + 1, "R6 chain waits for doorbell",
        64'(fetch_n - f0), 1);
    ring(3, 2);
    wait_cpl(c0 + 1);
    chk(cby_log[c0[7:0]] == 24'd33, "R6 resumed chain sum", cby_log[c0[7:0]], 33);
  endtask

  task automatic t_rr();
    int c0;
    c0 = cpl_n;
    for (int c = 0; c < 3; c++) begin
      setup(c, 64'(c) << 8, 8);
      mem[c * 16]     = slot(64'hA000, 16'(100 * c + 1), 1'b0);
      mem[c * 16 + 1] = slot(64'hB000, 16'(100 * c + 2), 1'b0);
    end
    @(negedge clk); cpl_ready = 1'b0;
    ring(0, 2); ring(1, 2); ring(2, 2);
    repeat (10) @(negedge clk);
    chk(cpl_valid && cpl_ch == 2'd0, "R9 completion held while stalled",
        {cpl_valid, cpl_ch}, 64'h4);
    cpl_ready = 1'b1;
    wait_cpl(c0 + 6);
    for (int k = 0; k < 6; k++)
      chk(cch_log[(c0 + k) % 256] == 2'(k % 3), "R7 rotating grant order",
          cch_log[(c0 + k) % 256], 64'(k % 3));
  endtask

  task automatic t_bad();
    int c0, f0;
    do_reset();
    chk(!db_err, "R1 error clear after reset", db_err, 0);
    c0 = cpl_n;
    ring(4, 1);
    repeat (20) @(negedge clk);
    chk(db_err && cpl_n == c0, "R8 out-of-range channel", db_err, 1);
    do_reset();
    f0 = fetch_n; c0 = cpl_n;
    setup(0, 64'h0, 4);
    ring(0, 5);
    repeat (20) @(negedge clk);
    chk(db_err && fetch_n == f0, "R8 index beyond ring ignored",
        64'(fetch_n - f0), 0);
    ring(0, 1);
    wait_cpl(c0 + 1);
    chk(cby_log[c0[7:0]] == 24'd1 && db_err, "R8 ring intact, error sticky",
        cby_log[c0[7:0]], 1);
  endtask

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single();
    t_chain();
    t_zero();
    t_wrap();
    t_wait();
    t_rr();
    t_bad();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule